// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This block owns the program counter of a small fixed-length 32-bit core and decides, once per clock-enable, where the next fetch comes from. The decoder in front of it sends one strobe per command: branch-if-zero, branch-if-not-equal, jump-through-register and jump-and-link-through-register. With the strobe it sends the two register read values and the 16-bit immediate field. When no strobe is raised, fetch proceeds sequentially. On a jump-and-link the unit also issues a one-cycle write request that puts the return address into the fixed link register.

Branch destinations are measured from the address of the following instruction. The immediate is a signed count of 32-bit words. Register jumps take their destination straight from the first register value. Two or more strobes in one enabled cycle are treated as a decode fault. The unit flags the fault and falls back to sequential fetch.

Top module: `npc_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `pc_q` to 0x00000000 and holds `link_we` and `cmd_err` low.
- R2: While `adv_en` is low, `pc_q` keeps its value, every command strobe is ignored, and `link_we` and `cmd_err` are low after the next edge.
- R3: On an enabled edge with no command strobe, `pc_q` becomes `pc_q + 4`.
- R4: A branch-if-zero (`cmd_bz`) is taken when `rs_val` is zero and otherwise falls through to `pc_q + 4`; `rt_val` has no effect on it.
- R5: A branch-if-not-equal (`cmd_bne`) is taken when `rs_val` differs from `rt_val` and otherwise falls through to `pc_q + 4`.
- R6: A taken branch loads `pc_q + 4 + (sign-extended imm16 << 2)`. Bit 15 of `imm16` is the sign bit, so negative offsets move backwards, and the sum wraps modulo 2^32.
- R7: A jump-register (`cmd_jr`) loads `rs_val` into `pc_q`; `rt_val` and `imm16` have no effect on it.
- R8: A jump-and-link (`cmd_jalr`) loads `rs_val` into `pc_q`. After the same edge, `link_we` is high for exactly one cycle with `link_idx` = 31 and `link_data` equal to the value of `pc_q` before that edge plus 4.
- R9: When more than one command strobe is high on an enabled edge, `cmd_err` is high for the following cycle, `pc_q` becomes `pc_q + 4`, and no link write is issued.
- R10: `link_we` and `cmd_err` are never high in the same cycle, and each is low in any cycle that does not follow an enabled edge with its triggering command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | Clock-enable for the PC update |
| cmd_bz | input | 1 | Branch if `rs_val` is zero |
| cmd_bne | input | 1 | Branch if `rs_val` differs from `rt_val` |
| cmd_jr | input | 1 | Jump to `rs_val` |
| cmd_jalr | input | 1 | Jump to `rs_val` and write the link register |
| rs_val | input | 32 | First register read value |
| rt_val | input | 32 | Second register read value |
| imm16 | input | 16 | Signed word offset for branches |
| pc_q | output | 32 | Current program counter |
| link_we | output | 1 | One-cycle link register write request |
| link_idx | output | 5 | Destination register index of the link write |
| link_data | output | 32 | Return address of the link write |
| cmd_err | output | 1 | More than one command strobe was seen on the last enabled edge |

## Verification
The properties assume that the strobes, `adv_en` and the operand values are stable across each edge and settle to known values once reset is released. They also assume that reset is applied from time zero. They make no assumption that the strobes are one-hot: the multi-strobe case is itself a checked behaviour. The stimulus drives every input on the falling edge only, and holds reset over the first edges. Random operands are biased so that zero and equal register values occur often, which exercises both outcomes of each branch condition.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned IMM_W      = 16;
  localparam int unsigned RIDX_W     = 5;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned WORD_SHIFT = $clog2(WORD_BYTES);
  localparam int unsigned NCMD       = 4;

  // strobe positions inside the packed command vector
  localparam int unsigned CMD_BZ   = 0;
  localparam int unsigned CMD_BNE  = 1;
  localparam int unsigned CMD_JR   = 2;
  localparam int unsigned CMD_JALR = 3;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [2:0] {
    K_NONE, K_BZ, K_BNE, K_JR, K_JALR, K_MULTI
  } cmd_kind_e;

  function automatic addr_t seq_pc(input addr_t pc);
    return pc + addr_t'(WORD_BYTES);
  endfunction

  function automatic addr_t word_offset(input logic [IMM_W-1:0] imm);
    addr_t ext;
    ext = {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};
    return ext << WORD_SHIFT;
  endfunction

  function automatic addr_t branch_pc(input addr_t pc, input logic [IMM_W-1:0] imm);
    return seq_pc(pc) + word_offset(imm);
  endfunction
endpackage

// File: rtl/npc_cmd_decode.sv
module npc_cmd_decode
  import npc_pkg::*;
#(
  parameter int unsigned N = NCMD
) (
  input  logic [N-1:0] strobes,
  output cmd_kind_e    kind,
  output logic         multi
);
  logic [$clog2(N+1)-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) cnt = cnt + {{($clog2(N+1)-1){1'b0}}, strobes[i]};
  end

  assign multi = (cnt > 1);

  always_comb begin
    kind = K_NONE;
    if (multi)                   kind = K_MULTI;
    else if (strobes[CMD_BZ])    kind = K_BZ;
    else if (strobes[CMD_BNE])   kind = K_BNE;
    else if (strobes[CMD_JR])    kind = K_JR;
    else if (strobes[CMD_JALR])  kind = K_JALR;
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
(
  input  addr_t            pc,
  input  logic [IMM_W-1:0] imm,
  output addr_t            seq,
  output addr_t            br
);
  assign seq = seq_pc(pc);
  assign br  = branch_pc(pc, imm);
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
(
  input  cmd_kind_e kind,
  input  addr_t     rs,
  input  addr_t     rt,
  input  addr_t     seq,
  input  addr_t     br,
  output addr_t     next_pc,
  output logic      taken,
  output logic      link_req
);
  always_comb begin
    taken    = 1'b0;
    link_req = 1'b0;
    next_pc  = seq;
    unique case (kind)
      K_BZ:  taken = (rs == '0);
      K_BNE: taken = (rs != rt);
      K_JR:  next_pc = rs;
      K_JALR: begin
        next_pc  = rs;
        link_req = 1'b1;
      end
      default: ;
    endcase
    if (taken) next_pc = br;
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  parameter int unsigned       LINK_REG = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_en,
  input  logic              cmd_bz,
  input  logic              cmd_bne,
  input  logic              cmd_jr,
  input  logic              cmd_jalr,
  input  logic [ADDR_W-1:0] rs_val,
  input  logic [ADDR_W-1:0] rt_val,
  input  logic [IMM_W-1:0]  imm16,
  output logic [ADDR_W-1:0] pc_q,
  output logic              link_we,
  output logic [RIDX_W-1:0] link_idx,
  output logic [ADDR_W-1:0] link_data,
  output logic              cmd_err
);
  logic [NCMD-1:0] strobe_w;
  cmd_kind_e       kind_w;
  logic            multi_w;
  logic            take_w;
  logic            link_req_w;
  addr_t           seq_w, br_w, next_w;

  always_comb begin
    strobe_w           = '0;
    strobe_w[CMD_BZ]   = cmd_bz;
    strobe_w[CMD_BNE]  = cmd_bne;
    strobe_w[CMD_JR]   = cmd_jr;
    strobe_w[CMD_JALR] = cmd_jalr;
  end

  npc_cmd_decode #(.N(NCMD)) u_dec (.strobes(strobe_w), .kind(kind_w), .multi(multi_w));
  npc_target u_tgt (.pc(pc_q), .imm(imm16), .seq(seq_w), .br(br_w));
  npc_select u_sel (
    .kind(kind_w), .rs(rs_val), .rt(rt_val), .seq(seq_w), .br(br_w),
    .next_pc(next_w), .taken(take_w), .link_req(link_req_w)
  );

  assign link_idx = RIDX_W'(LINK_REG);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= RESET_PC;
      link_we   <= 1'b0;
      link_data <= '0;
      cmd_err   <= 1'b0;
    end else begin
      link_we <= 1'b0;
      cmd_err <= 1'b0;
      if (adv_en) begin
        pc_q    <= next_w;
        link_we <= link_req_w;
        cmd_err <= multi_w;
        if (link_req_w) link_data <= seq_w;
      end
    end
  end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
  import npc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              adv_en,
  input logic              cmd_bz,
  input logic              cmd_bne,
  input logic              cmd_jr,
  input logic              cmd_jalr,
  input logic [ADDR_W-1:0] rs_val,
  input logic [ADDR_W-1:0] rt_val,
  input logic [ADDR_W-1:0] pc_q,
  input logic              link_we,
  input logic [RIDX_W-1:0] link_idx,
  input logic [ADDR_W-1:0] link_data,
  input logic              cmd_err,
  input logic              take_w
);
  logic [NCMD-1:0] s;
  assign s = {cmd_jalr, cmd_jr, cmd_bne, cmd_bz};

  p_reset_r1: assert property (@(posedge clk) rst |=> (pc_q == '0 && !link_we && !cmd_err));
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !adv_en |=> ($stable(pc_q) && !link_we && !cmd_err));
  p_seq_r3: assert property (@(posedge clk) disable iff (rst)
    (adv_en && s == '0) |=> (pc_q == $past(pc_q) + 32'd4));
  p_bz_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (adv_en && $onehot0(s) && cmd_bz && take_w) |-> (rs_val == '0));
  p_bne_diff_r5: assert property (@(posedge clk) disable iff (rst)
    (adv_en && $onehot0(s) && cmd_bne && take_w) |-> (rs_val != rt_val));
  p_jr_r7: assert property (@(posedge clk) disable iff (rst)
    (adv_en && $onehot0(s) && cmd_jr) |=> (pc_q == $past(rs_val) && !link_we));
  p_jalr_r8: assert property (@(posedge clk) disable iff (rst)
    (adv_en && $onehot0(s) && cmd_jalr) |=>
      (pc_q == $past(rs_val) && link_we && link_idx == 5'd31 && link_data == $past(pc_q) + 32'd4));
  p_multi_r9: assert property (@(posedge clk) disable iff (rst)
    (adv_en && $countones(s) > 1) |=> (cmd_err && !link_we && pc_q == $past(pc_q) + 32'd4));
  p_excl_r10: assert property (@(posedge clk) disable iff (rst) $onehot0({link_we, cmd_err}));
endmodule

bind npc_unit npc_unit_chk u_chk (
  .clk(clk), .rst(rst), .adv_en(adv_en), .cmd_bz(cmd_bz), .cmd_bne(cmd_bne),
  .cmd_jr(cmd_jr), .cmd_jalr(cmd_jalr), .rs_val(rs_val), .rt_val(rt_val),
  .pc_q(pc_q), .link_we(link_we), .link_idx(link_idx), .link_data(link_data),
  .cmd_err(cmd_err), .take_w(take_w)
);

// File: tb/npc_unit_tb_top.sv
`timescale 1ns/1ps
module npc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv_en = 1'b0;
  logic        cmd_bz = 1'b0, cmd_bne = 1'b0, cmd_jr = 1'b0, cmd_jalr = 1'b0;
  logic [31:0] rs_val = '0, rt_val = '0;
  logic [15:0] imm16 = '0;
  logic [31:0] pc_q, link_data;
  logic        link_we, cmd_err;
  logic [4:0]  link_idx;

  int errs = 0, checks = 0;
  bit done = 0;
  logic [31:0] m_pc;

  always #10 clk = ~clk;

  npc_unit dut_i (
    .clk(clk), .rst(rst), .adv_en(adv_en), .cmd_bz(cmd_bz), .cmd_bne(cmd_bne),
    .cmd_jr(cmd_jr), .cmd_jalr(cmd_jalr), .rs_val(rs_val), .rt_val(rt_val),
    .imm16(imm16), .pc_q(pc_q), .link_we(link_we), .link_idx(link_idx),
    .link_data(link_data), .cmd_err(cmd_err)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // offset as a signed multiply, independent of shift-based formulation
  function automatic logic [31:0] tgt(input logic [31:0] pc, input logic [15:0] imm);
    int signed off;
    off = $signed(imm);
    return pc + 32'd4 + 32'(off * 4);
  endfunction

  // cmd order: {jalr, jr, bne, bz}
  task automatic step(input string tag, input bit en, input logic [3:0] c,
                      input logic [31:0] rs, input logic [31:0] rt, input logic [15:0] imm);
    logic [31:0] exp_pc;
    bit exp_we, exp_err;
    int n;
    @(negedge clk);
    adv_en = en; {cmd_jalr, cmd_jr, cmd_bne, cmd_bz} = c;
    rs_val = rs; rt_val = rt; imm16 = imm;
    n = 0;
    for (int i = 0; i < 4; i++) n += int'(c[i]);
    exp_pc = m_pc; exp_we = 0; exp_err = 0;
    if (en) begin
      exp_pc = m_pc + 32'd4;
      if (n > 1) exp_err = 1;
      else if (c[0] && rs == 0) exp_pc = tgt(m_pc, imm);
      else if (c[1] && rs != rt) exp_pc = tgt(m_pc, imm);
      else if (c[2]) exp_pc = rs;
      else if (c[3]) begin exp_pc = rs; exp_we = 1; end
    end
    @(posedge clk); #2;
    chk(tag, "pc", pc_q, exp_pc);
    chk(tag, "link_we", {31'd0, link_we}, {31'd0, exp_we});
    chk(tag, "cmd_err", {31'd0, cmd_err}, {31'd0, exp_err});
    if (exp_we) begin
      chk(tag, "link_idx", {27'd0, link_idx}, 32'd31);
      chk(tag, "link_data", link_data, m_pc + 32'd4);
    end
    m_pc = exp_pc;
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "reset pc", pc_q, 32'h0);
    chk("R1", "reset link_we", {31'd0, link_we}, 32'd0);
    chk("R1", "reset cmd_err", {31'd0, cmd_err}, 32'd0);
    @(negedge clk); rst = 1'b0; m_pc = 32'h0;

    step("R3", 1, 4'b0000, 0, 0, 0);
    step("R3", 1, 4'b0000, 5, 7, 16'hffff);
    step("R2", 0, 4'b1000, 32'h100, 0, 0);
    step("R2", 0, 4'b0001, 0, 0, 16'h0010);
    step("R4", 1, 4'b0001, 0, 32'hdead, 16'h0010);
    step("R4", 1, 4'b0001, 1, 0, 16'h0010);
    step("R6", 1, 4'b0001, 0, 0, 16'hfffe);
    step("R6", 1, 4'b0001, 0, 0, 16'h8000);
    step("R5", 1, 4'b0010, 3, 3, 16'h0040);
    step("R5", 1, 4'b0010, 3, 4, 16'h0040);
    step("R7", 1, 4'b0100, 32'h0000_1000, 32'h1234, 16'h7fff);
    step("R8", 1, 4'b1000, 32'hffff_fffc, 0, 0);
    step("R6", 1, 4'b0010, 1, 2, 16'h0001);
    step("R10", 1, 4'b0000, 0, 0, 0);
    step("R9", 1, 4'b0101, 0, 0, 16'h0100);
    step("R9", 1, 4'b1111, 32'h40, 0, 0);
    step("R8", 1, 4'b1000, 32'h2000, 0, 0);
    step("R8", 1, 4'b1000, 32'h3000, 0, 0);
    step("R2", 0, 4'b0000, 0, 0, 0);

    for (int k = 0; k < 400; k++) begin
      logic [3:0]  c;
      logic [31:0] rs, rt;
      int unsigned r;
      r = $urandom_range(0, 9);
      case (r)
        0, 1: c = 4'b0001;
        2, 3: c = 4'b0010;
        4:    c = 4'b0100;
        5:    c = 4'b1000;
        6:    c = 4'($urandom_range(0, 15));
        default: c = 4'b0000;
      endcase
      rs = ($urandom_range(0, 3) == 0) ? 32'd0 : $urandom;
      rt = ($urandom_range(0, 2) == 0) ? rs : $urandom;
      step("R10", ($urandom_range(0, 7) != 0), c, rs, rt, 16'($urandom));
    end

    @(negedge clk); rst = 1'b1; @(posedge clk); #2;
    chk("R1", "re-reset pc", pc_q, 32'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule